// File: doc/BRIEF.md
# Pipeline hazard and forwarding controller

This block is the hazard control logic for an in-order pipeline with five stages: fetch, decode with register read, execute or address generation, memory access and register write-back. Each cycle it looks at the register numbers held in the decode and execute stages and at the destinations held in the two later pipeline registers. From these it decides where each ALU operand should come from, and whether the front of the pipeline must hold or be cleared.

Each ALU input has its own multiplexer and its own select code. The select picks the value read from the register file in decode, or a newer result held in the execute/memory register or the memory/writeback register. A value that a load produces is not ready for the instruction directly behind it. In that case the block holds the PC and the fetch/decode register for one cycle and sends a no-op into the decode/execute register. After that cycle the loaded value is forwarded from memory/writeback. A taken or redirected branch is resolved in execute. When that happens, the block clears the two younger instructions in fetch/decode and decode/execute to no-ops.

The block is purely combinational. Its outputs drive the pipeline-register enables and the operand multiplexers in the same cycle.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An operand select is 2'b00 (register file) when neither the execute/memory nor the memory/writeback destination supplies that operand's source register.
- R2: An operand select is 2'b10 when the execute/memory register has write enable set and a nonzero destination equal to the operand's source.
- R3: An operand select is 2'b01 when the memory/writeback register has write enable set and a nonzero destination equal to the source, and R2 does not apply.
- R4: When both later registers can supply the same source, the select is 2'b10, because execute/memory holds the newer value.
- R5: Register 0 is never forwarded. An operand whose source is register 0 always selects 2'b00.
- R6: A stage whose write enable is low never supplies a forwarded value, even when its destination matches.
- R7: The two operand selects are computed independently, each from its own source register.
- R8: A load-use stall is raised when the execute-stage instruction is a load with write enable and a nonzero destination, and a used decode-stage source equals that destination. The stall raises stall_pc, stall_ifid and idex_nop together.
- R9: A non-load producer in execute, or an unused decode source, never causes a stall.
- R10: A taken branch in execute raises flush_ifid and idex_nop in the same cycle.
- R11: A flush takes priority over a stall. While ex_br_taken is high, stall_pc and stall_ifid stay low.
- R12: With no load-use hazard and no taken branch, stall_pc, stall_ifid, idex_nop and flush_ifid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | First source register of the instruction in decode |
| id_rs1_used | input | 1 | The decode instruction reads id_rs1 |
| id_rs2 | input | AW | Second source register of the instruction in decode |
| id_rs2_used | input | 1 | The decode instruction reads id_rs2 |
| ex_rs1 | input | AW | Source register feeding ALU input A in execute |
| ex_rs2 | input | AW | Source register feeding ALU input B in execute |
| ex_rd | input | AW | Destination of the instruction in execute |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination held in the execute/memory register |
| mem_we | input | 1 | Write enable held in the execute/memory register |
| wb_rd | input | AW | Destination held in the memory/writeback register |
| wb_we | input | 1 | Write enable held in the memory/writeback register |
| ex_br_taken | input | 1 | Branch resolved in execute redirects fetch |
| fwd_a_sel | output | 2 | Select for ALU input A: 00 file, 10 exe/mem, 01 mem/wb |
| fwd_b_sel | output | 2 | Select for ALU input B, same encoding |
| stall_pc | output | 1 | Hold the program counter |
| stall_ifid | output | 1 | Hold the fetch/decode register |
| idex_nop | output | 1 | Load a no-op into the decode/execute register |
| flush_ifid | output | 1 | Clear the fetch/decode register to a no-op |

## Verification
The bench builds the block with AW = 3, which gives eight architectural registers. At that width every combination of one operand's source, both later destinations and both write enables can be swept, which covers all forwarding priorities and the register-0 exclusion. The decode sources, execute destination, use flags, load flag, write enable and branch flag are also swept in full, so every overlap between a stall and a flush is applied at least once.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } opnd_sel_e;

  localparam int NSRC = 2;
endpackage

// File: rtl/pipe_fwd_pick.sv
module pipe_fwd_pick
  import pipe_hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output opnd_sel_e     sel,
  output logic          hit_mem,
  output logic          hit_wb
);
  // A later stage can supply a source when it writes a real register equal to it
  function automatic logic producer_match(
    input logic [AW-1:0] s,
    input logic [AW-1:0] d,
    input logic          we
  );
    return we && (d != '0) && (d == s);
  endfunction

  assign hit_mem = producer_match(src, mem_rd, mem_we);
  assign hit_wb  = producer_match(src, wb_rd, wb_we);

  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/pipe_lu_detect.sv
module pipe_lu_detect #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC*AW-1:0] id_src_flat,
  input  logic [NSRC-1:0]    id_used,
  input  logic [AW-1:0]      ex_rd,
  input  logic               ex_we,
  input  logic               ex_is_load,
  output logic               lu_hit
);
  logic [NSRC-1:0] src_hit;
  logic            load_pending;

  assign load_pending = ex_is_load && ex_we && (ex_rd != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_hit[g] = id_used[g] && (id_src_flat[g*AW +: AW] == ex_rd);
  end

  assign lu_hit = load_pending && (|src_hit);
endmodule

// File: rtl/pipe_ctl_arb.sv
module pipe_ctl_arb (
  input  logic lu_hit,
  input  logic br_taken,
  output logic stall_pc,
  output logic stall_ifid,
  output logic idex_nop,
  output logic flush_ifid
);
  logic stall_ok;

  // A redirect discards the stalled instruction, so holding it is pointless
  assign stall_ok   = lu_hit && !br_taken;
  assign stall_pc   = stall_ok;
  assign stall_ifid = stall_ok;
  assign flush_ifid = br_taken;
  assign idex_nop   = br_taken || lu_hit;
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import pipe_hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic          id_rs1_used,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rs2_used,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  input  logic          ex_br_taken,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic          stall_pc,
  output logic          stall_ifid,
  output logic          idex_nop,
  output logic          flush_ifid
);
  localparam int SRCW = NSRC * AW;

  logic [AW-1:0]   ex_src   [NSRC];
  opnd_sel_e       op_sel   [NSRC];
  logic [NSRC-1:0] hit_mem;
  logic [NSRC-1:0] hit_wb;
  logic [SRCW-1:0] id_src_flat;
  logic [NSRC-1:0] id_used;
  logic            lu_hit;

  assign ex_src[0]   = ex_rs1;
  assign ex_src[1]   = ex_rs2;
  assign id_src_flat = {id_rs2, id_rs1};
  assign id_used     = {id_rs2_used, id_rs1_used};

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    pipe_fwd_pick #(.AW(AW)) u_pick (
      .src     (ex_src[g]),
      .mem_rd  (mem_rd),
      .mem_we  (mem_we),
      .wb_rd   (wb_rd),
      .wb_we   (wb_we),
      .sel     (op_sel[g]),
      .hit_mem (hit_mem[g]),
      .hit_wb  (hit_wb[g])
    );
  end

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];

  pipe_lu_detect #(.AW(AW), .NSRC(NSRC)) u_lu (
    .id_src_flat (id_src_flat),
    .id_used     (id_used),
    .ex_rd       (ex_rd),
    .ex_we       (ex_we),
    .ex_is_load  (ex_is_load),
    .lu_hit      (lu_hit)
  );

  pipe_ctl_arb u_arb (
    .lu_hit     (lu_hit),
    .br_taken   (ex_br_taken),
    .stall_pc   (stall_pc),
    .stall_ifid (stall_ifid),
    .idex_nop   (idex_nop),
    .flush_ifid (flush_ifid)
  );
endmodule

// File: rtl/pipe_hazard_chk.sv
module pipe_hazard_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic          ex_is_load,
  input logic          mem_we,
  input logic          wb_we,
  input logic          ex_br_taken,
  input logic [1:0]    fwd_a_sel,
  input logic [1:0]    fwd_b_sel,
  input logic          stall_pc,
  input logic          stall_ifid,
  input logic          idex_nop,
  input logic          flush_ifid,
  input logic [1:0]    hit_mem,
  input logic          lu_hit
);
  always_comb begin
    AST_ZERO_SRC_A: assert (ex_rs1 != '0 || fwd_a_sel == 2'b00) else $error("zero src A forwarded"); // R5
    AST_ZERO_SRC_B: assert (ex_rs2 != '0 || fwd_b_sel == 2'b00) else $error("zero src B forwarded"); // R5
    AST_WE_LOW_NO_FWD: assert (mem_we || wb_we || (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00)) else $error("fwd without write"); // R6
    AST_MEM_WINS_A: assert (!hit_mem[0] || fwd_a_sel == 2'b10) else $error("exe/mem not preferred A"); // R4
    AST_STALL_IMPLIES_NOP: assert (!stall_pc || (idex_nop && stall_ifid)) else $error("stall without bubble"); // R8
    AST_STALL_NEEDS_LOAD: assert (!stall_pc || ex_is_load) else $error("stall without load"); // R9
    AST_FLUSH_WINS: assert (!ex_br_taken || (flush_ifid && idex_nop && !stall_pc && !stall_ifid)) else $error("flush lost"); // R11
    AST_QUIET: assert (ex_br_taken || lu_hit || !(idex_nop || flush_ifid || stall_pc)) else $error("spurious control"); // R12
  end
endmodule

bind pipe_hazard_unit pipe_hazard_chk #(.AW(AW)) u_chk (
  .ex_rs1      (ex_rs1),
  .ex_rs2      (ex_rs2),
  .ex_is_load  (ex_is_load),
  .mem_we      (mem_we),
  .wb_we       (wb_we),
  .ex_br_taken (ex_br_taken),
  .fwd_a_sel   (fwd_a_sel),
  .fwd_b_sel   (fwd_b_sel),
  .stall_pc    (stall_pc),
  .stall_ifid  (stall_ifid),
  .idex_nop    (idex_nop),
  .flush_ifid  (flush_ifid),
  .hit_mem     (hit_mem),
  .lu_hit      (lu_hit)
);

// File: tb/sim_pipe_hazard_unit.sv
module sim_pipe_hazard_unit;
  localparam int AW = 3;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [AW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic id_rs1_used = 0, id_rs2_used = 0, ex_we = 0, ex_is_load = 0;
  logic mem_we = 0, wb_we = 0, ex_br_taken = 0;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic stall_pc, stall_ifid, idex_nop, flush_ifid;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  pipe_hazard_unit #(.AW(AW)) u0 (
    .id_rs1(id_rs1), .id_rs1_used(id_rs1_used), .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we), .ex_br_taken(ex_br_taken),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .stall_pc(stall_pc), .stall_ifid(stall_ifid),
    .idex_nop(idex_nop), .flush_ifid(flush_ifid)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Forward source weight: exe/mem counts 2, mem/wb counts 1, newer wins
  function automatic int exp_sel(int s, int md, int mw, int wd, int ww);
    int v = 0;
    if (s != 0 && ww != 0 && wd == s) v = 1;
    if (s != 0 && mw != 0 && md == s) v = 2;
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // Reset-like idle state: everything zero
    @(negedge clk); #1;
    check("R1 idle sel A", fwd_a_sel, 0);
    check("R1 idle sel B", fwd_b_sel, 0);
    check("R12 idle stall", {stall_pc, stall_ifid, idex_nop, flush_ifid}, 0);

    // Forwarding sweep over every source / destination / enable combination
    for (int s = 0; s < NR; s++)
      for (int md = 0; md < NR; md++)
        for (int wd = 0; wd < NR; wd++)
          for (int mw = 0; mw < 2; mw++)
            for (int ww = 0; ww < 2; ww++) begin
              int ea, eb, sb;
              string tg;
              sb = NR - 1 - s;
              @(negedge clk);
              ex_rs1 = AW'(s); ex_rs2 = AW'(sb);
              mem_rd = AW'(md); wb_rd = AW'(wd);
              mem_we = mw[0]; wb_we = ww[0];
              #1;
              ea = exp_sel(s, md, mw, wd, ww);
              eb = exp_sel(sb, md, mw, wd, ww);
              if (s == 0) tg = "R5";
              else if (mw == 0 && ww == 0) tg = "R6";
              else if (ea == 2 && ww != 0 && wd == s) tg = "R4";
              else if (ea == 2) tg = "R2";
              else if (ea == 1) tg = "R3";
              else tg = "R1";
              check(tg, fwd_a_sel, ea);
              check("R7 operand B", fwd_b_sel, eb);
              check("R12 no stall during fwd", {stall_pc, stall_ifid, idex_nop, flush_ifid}, 0);
            end
    mem_we = 0; wb_we = 0;

    // Load-use and flush sweep
    for (int r1 = 0; r1 < NR; r1++)
      for (int r2 = 0; r2 < NR; r2++)
        for (int d = 0; d < NR; d++)
          for (int m = 0; m < 32; m++) begin
            bit u1, u2, ld, we, br, hit;
            string tg;
            int st, ex;
            u1 = m[0]; u2 = m[1]; ld = m[2]; we = m[3]; br = m[4];
            @(negedge clk);
            id_rs1 = AW'(r1); id_rs2 = AW'(r2); ex_rd = AW'(d);
            id_rs1_used = u1; id_rs2_used = u2; ex_is_load = ld; ex_we = we; ex_br_taken = br;
            #1;
            hit = ld && we && d != 0 && ((u1 && r1 == d) || (u2 && r2 == d));
            st = (hit && !br) ? 1 : 0;
            if (br) tg = hit ? "R11" : "R10";
            else if (hit) tg = "R8";
            else if (!ld || !(u1 || u2)) tg = "R9";
            else tg = "R12";
            ex = st * 8 + st * 4 + ((hit || br) ? 2 : 0) + (br ? 1 : 0);
            check(tg, {stall_pc, stall_ifid, idex_nop, flush_ifid}, ex);
          end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule